// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Reader

This block is the read side of a word memory that is split into two banks: one holds the words at even addresses and one holds the words at odd addresses. Each bank has its own index counter. A random-access cycle loads a word address. Bit 0 of that address chooses the bank that supplies the first word, and the remaining bits set the index in both banks. After that, each rising edge of the read strobe is one burst beat. On every beat the output moves to the other bank and the counter of the bank just read steps forward by one. Words therefore stream in linear address order with no break, wrap past the top of the array, and continue for any burst length.

Deselecting the block puts it in standby. In standby the output drive is released and the counters and bank pointer are held. When the block is selected again with latch-enable low, the burst picks up at the next sequential word. When it is selected again with latch-enable high, a fresh random-access cycle starts. All pins are sampled on one system clock. Each bank is a read-only synchronous array, written so that it maps onto block RAM, and its contents are fixed when the array is built.

Top module: `ilv_burst_reader`

## Requirements
- R1: While reset is held and on the first clock after it, `data_out` is 0 and `data_oe` is 0.
- R2: `data_oe` becomes the inverse of the `cs_n` value sampled at a clock edge and takes effect right after that same edge.
- R3: Bank 0 (even) index i holds the linear word w = 2*i and bank 1 (odd) index i holds w = 2*i+1. The word stored at w is the zero-extended w XOR `SEED` (default 16'hC300).
- R4: A clock edge that samples `ale`=1 and `cs_n`=0 with `addr[0]`=0 loads both counters with `addr[BANK_AW:1]` and selects the even bank. Two clock edges later, `data_out` shows the word w = `addr`.
- R5: The same cycle with `addr[0]`=1 loads the odd counter with `addr[BANK_AW:1]` and the even counter with that value plus one, and selects the odd bank. The first word, w = `addr`, appears two edges later.
- R6: A beat is an edge that samples `rd`=1 when the previous edge sampled `rd`=0, with `cs_n`=0 and `ale`=0. On a beat the counter of the current bank increments and the other bank is selected, so `data_out` shows the next linear word two edges later.
- R7: The counters wrap modulo 2^BANK_AW. After the top word the stream continues at word 0, including when an odd start makes the even counter wrap at load time.
- R8: While `cs_n` is sampled high, read strobe edges and latch-enable are ignored: `data_out`, the counters and the bank pointer keep their values.
- R9: Reselecting with `ale` low resumes the burst. The next beat delivers the word after the last one output before standby.
- R10: Reselecting with `ale` high starts a new random-access cycle at the new address, as in R4 and R5.
- R11: `data_out` changes only two edges after a random-access cycle or a beat. Holding `rd` high, or toggling `rd` while `ale` is high, produces no extra beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Latch-enable; starts a random-access cycle when high with chip select low |
| cs_n | input | 1 | Active-low chip select; high enters standby |
| rd | input | 1 | Read strobe; each rising edge is one burst beat |
| addr | input | BANK_AW+1 | Word address; bit 0 picks the starting bank |
| data_out | output | DATA_W | Registered data word |
| data_oe | output | 1 | Output drive enable; 0 means high impedance |

## Verification
A wrong bank pointer shows up on the very next word. The word is taken from the wrong bank, so its low address bit has the wrong parity, and this is visible at `data_out` two clocks after the beat. A counter that is off by one, fails to advance, or advances in the wrong bank shows as a skipped or repeated word. For the even-start case this appears within two beats, and for the odd-start case it appears at the first even word. State that is lost or disturbed during standby appears on the first beat after reselection. The bench keeps its own model of the linear word address and compares `data_out` and `data_oe` on every clock. This catches such errors within two clocks of the event that exposes them.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {BANK_EVEN = 1'b0, BANK_ODD = 1'b1} bank_e;

  // linear word number held at a bank index
  function automatic int unsigned linear_word(int unsigned idx, int unsigned odd);
    return idx * 2 + odd;
  endfunction
endpackage

// File: rtl/ilv_pin_sampler.sv
module ilv_pin_sampler #(
  parameter int BANK_AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ale,
  input  logic             cs_n,
  input  logic             rd,
  input  logic [BANK_AW:0] addr,
  output logic             nla,
  output logic             beat,
  output logic             csn_q,
  output logic [BANK_AW-1:0] start_idx,
  output logic             start_odd
);
  logic ale_q, rd_q, rd_prev;
  logic [BANK_AW:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q   <= 1'b0;
      csn_q   <= 1'b1;
      rd_q    <= 1'b0;
      rd_prev <= 1'b0;
      addr_q  <= '0;
    end else begin
      ale_q   <= ale;
      csn_q   <= cs_n;
      rd_q    <= rd;
      rd_prev <= rd_q;
      addr_q  <= addr;
    end
  end

  assign nla       = ale_q & ~csn_q;
  assign beat      = rd_q & ~rd_prev & ~csn_q & ~ale_q;
  assign start_idx = addr_q[BANK_AW:1];
  assign start_odd = addr_q[0];
endmodule

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl
  import ilv_pkg::*;
#(
  parameter int BANK_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nla,
  input  logic               beat,
  input  logic [BANK_AW-1:0] start_idx,
  input  logic               start_odd,
  output logic [BANK_AW-1:0] even_d,
  output logic [BANK_AW-1:0] odd_d,
  output logic [BANK_AW-1:0] even_q,
  output logic [BANK_AW-1:0] odd_q,
  output bank_e              sel_q
);
  bank_e sel_d;

  always_comb begin
    even_d = even_q;
    odd_d  = odd_q;
    sel_d  = sel_q;
    if (nla) begin
      odd_d  = start_idx;
      even_d = start_idx + BANK_AW'(start_odd);
      sel_d  = start_odd ? BANK_ODD : BANK_EVEN;
    end else if (beat) begin
      if (sel_q == BANK_ODD) begin
        odd_d = odd_q + 1'b1;
        sel_d = BANK_EVEN;
      end else begin
        even_d = even_q + 1'b1;
        sel_d  = BANK_ODD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      even_q <= '0;
      odd_q  <= '0;
      sel_q  <= BANK_EVEN;
    end else begin
      even_q <= even_d;
      odd_q  <= odd_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/ilv_bank_rom.sv
module ilv_bank_rom
  import ilv_pkg::*;
#(
  parameter int                BANK_AW = 8,
  parameter int                DATA_W  = 16,
  parameter int                ODD     = 0,
  parameter logic [DATA_W-1:0] SEED    = 16'hC300
) (
  input  logic               clk,
  input  logic [BANK_AW-1:0] rd_idx,
  output logic [DATA_W-1:0]  dout
);
  localparam int DEPTH = 1 << BANK_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DATA_W'(linear_word(i, ODD)) ^ SEED;
  end

  always_ff @(posedge clk) begin
    dout <= mem[rd_idx];
  end
endmodule

// File: rtl/ilv_burst_reader.sv
module ilv_burst_reader
  import ilv_pkg::*;
#(
  parameter int                BANK_AW = 8,
  parameter int                DATA_W  = 16,
  parameter logic [DATA_W-1:0] SEED    = 16'hC300
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ale,
  input  logic               cs_n,
  input  logic               rd,
  input  logic [BANK_AW:0]   addr,
  output logic [DATA_W-1:0]  data_out,
  output logic               data_oe
);
  localparam int NBANK = 2;

  logic               nla, beat, csn_q, start_odd, ev_q;
  logic [BANK_AW-1:0] start_idx, even_d, odd_d, even_q, odd_q;
  bank_e              sel_q;
  logic [DATA_W-1:0]  bank_dout [NBANK];
  logic [DATA_W-1:0]  data_q;

  ilv_pin_sampler #(.BANK_AW(BANK_AW)) u_pins (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd(rd), .addr(addr),
    .nla(nla), .beat(beat), .csn_q(csn_q),
    .start_idx(start_idx), .start_odd(start_odd)
  );

  ilv_bank_ctrl #(.BANK_AW(BANK_AW)) u_ctrl (
    .clk(clk), .rst(rst), .nla(nla), .beat(beat),
    .start_idx(start_idx), .start_odd(start_odd),
    .even_d(even_d), .odd_d(odd_d), .even_q(even_q), .odd_q(odd_q),
    .sel_q(sel_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank_rom #(
      .BANK_AW(BANK_AW), .DATA_W(DATA_W), .ODD(b), .SEED(SEED)
    ) u_rom (
      .clk(clk),
      .rd_idx((b == 1) ? odd_d : even_d),
      .dout(bank_dout[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= 1'b0;
      data_q <= '0;
    end else begin
      ev_q <= nla | beat;
      if (ev_q)
        data_q <= (sel_q == BANK_ODD) ? bank_dout[1] : bank_dout[0];
    end
  end

  assign data_out = data_q;
  assign data_oe  = ~csn_q;
endmodule

// File: rtl/ilv_burst_checker.sv
module ilv_burst_checker
  import ilv_pkg::*;
#(
  parameter int BANK_AW = 8,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cs_n,
  input logic               data_oe,
  input logic [DATA_W-1:0]  data_out,
  input logic               nla,
  input logic               beat,
  input logic               start_odd,
  input logic               ev_q,
  input logic [BANK_AW-1:0] even_q,
  input logic [BANK_AW-1:0] odd_q,
  input bank_e              sel_q
);
  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !data_oe);

  // R2
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cs_n) && !$past(rst)) |-> data_oe);

  // R6
  sel_flip_chk: assert property (@(posedge clk) disable iff (rst)
    beat |=> (sel_q != $past(sel_q)));

  // R6
  even_step_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && sel_q == BANK_EVEN) |=>
      (even_q == BANK_AW'($past(even_q) + 1'b1)) && $stable(odd_q));

  // R6
  odd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && sel_q == BANK_ODD) |=>
      (odd_q == BANK_AW'($past(odd_q) + 1'b1)) && $stable(even_q));

  // R5
  odd_start_chk: assert property (@(posedge clk) disable iff (rst)
    (nla && start_odd) |=> (even_q == BANK_AW'(odd_q + 1'b1)) && sel_q == BANK_ODD);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nla && !beat) |=> $stable(even_q) && $stable(odd_q) && $stable(sel_q));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_q |=> $stable(data_out));
endmodule

bind ilv_burst_reader ilv_burst_checker #(.BANK_AW(BANK_AW), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .data_oe(data_oe), .data_out(data_out),
  .nla(nla), .beat(beat), .start_odd(start_odd), .ev_q(ev_q),
  .even_q(even_q), .odd_q(odd_q), .sel_q(sel_q)
);

// File: tb/test_ilv_burst_reader.sv
module test_ilv_burst_reader;
  localparam int          CLK_PERIOD = 10;
  localparam int          BANK_AW    = 8;
  localparam int          DATA_W     = 16;
  localparam logic [15:0] SEED       = 16'hC300;
  localparam int          DEPTH      = 1 << BANK_AW;
  localparam int          NWORD      = 2 * DEPTH;

  logic clk = 1'b0, rst = 1'b1, ale = 1'b0, cs_n = 1'b1, rd = 1'b0;
  logic [BANK_AW:0]  addr = '0;
  logic [DATA_W-1:0] data_out;
  logic              data_oe;

  int total = 0, bad = 0;
  string cur_req = "R1";

  ilv_burst_reader #(.BANK_AW(BANK_AW), .DATA_W(DATA_W), .SEED(SEED)) i_ilv_burst_reader (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd(rd), .addr(addr),
    .data_out(data_out), .data_oe(data_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] word_of(int w);
    return 16'(w % NWORD) ^ SEED;
  endfunction

  // behavioural model: linear word numbers per bank, pipelined expectation
  int m_even, m_odd, m_sel, m_rdp;
  int v1, v2;
  logic [15:0] d1, d2, exp_data;
  logic exp_oe;

  always @(posedge clk) begin
    if (rst) begin
      m_even = 0; m_odd = 0; m_sel = 0; m_rdp = 0;
      v1 = 0; v2 = 0; exp_data = '0; exp_oe = 1'b0;
    end else begin
      int ev;
      logic [15:0] nw;
      exp_oe = !cs_n;
      if (v2 != 0) exp_data = d2;
      v2 = v1; d2 = d1;
      ev = 0; nw = '0;
      if (ale && !cs_n) begin
        m_odd  = (int'(addr) / 2) % DEPTH;
        m_even = (m_odd + int'(addr[0])) % DEPTH;
        m_sel  = int'(addr[0]);
        ev = 1;
      end else if (rd && m_rdp == 0 && !cs_n && !ale) begin
        if (m_sel == 0) begin m_even = (m_even + 1) % DEPTH; m_sel = 1; end
        else begin m_odd = (m_odd + 1) % DEPTH; m_sel = 0; end
        ev = 1;
      end
      if (ev != 0)
        nw = (m_sel != 0) ? word_of(2 * m_odd + 1) : word_of(2 * m_even);
      v1 = ev; d1 = nw;
      m_rdp = int'(rd);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (data_out !== exp_data || data_oe !== exp_oe) begin
        bad++;
        $display("FAIL %s model: data_out=%h oe=%b expected data_out=%h oe=%b",
                 cur_req, data_out, data_oe, exp_data, exp_oe);
      end
    end
  end

  task automatic check_word(string req, int w);
    total++;
    if (data_out !== word_of(w) || data_oe !== 1'b1) begin
      bad++;
      $display("FAIL %s: data_out=%h oe=%b expected %h oe=1", req, data_out, data_oe, word_of(w));
    end
  endtask

  task automatic check_oe(string req, logic e);
    total++;
    if (data_oe !== e) begin
      bad++;
      $display("FAIL %s: data_oe=%b expected %b", req, data_oe, e);
    end
  endtask

  // entered at a negedge, returns at the negedge where the word is visible
  task automatic do_nla(int a);
    ale = 1'b1; cs_n = 1'b0; addr = (BANK_AW + 1)'(a);
    @(negedge clk); ale = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_beat();
    rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    total++;
    if (data_out !== '0 || data_oe !== 1'b0) begin
      bad++;
      $display("FAIL R1: data_out=%h oe=%b expected 0000 oe=0", data_out, data_oe);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (data_out !== '0 || data_oe !== 1'b0) begin
      bad++;
      $display("FAIL R1: after reset data_out=%h oe=%b expected 0000 oe=0", data_out, data_oe);
    end

    // R4 even start, R6 beats, R3 contents
    cur_req = "R4";
    do_nla(16);  check_word("R4", 16);
    cur_req = "R6";
    do_beat();   check_word("R6", 17);
    do_beat();   check_word("R6", 18);
    do_beat();   check_word("R3", 19);

    // R5 odd start
    cur_req = "R5";
    do_nla(37);  check_word("R5", 37);
    do_beat();   check_word("R5", 38);
    do_beat();   check_word("R5", 39);

    // R8 standby ignores strobes and latch-enable
    cur_req = "R8";
    cs_n = 1'b1;
    @(negedge clk); check_oe("R2", 1'b0);
    for (int k = 0; k < 4; k++) begin
      rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    end
    ale = 1'b1; addr = 9'd200; @(negedge clk); ale = 1'b0;
    @(negedge clk); @(negedge clk);
    total++;
    if (data_out !== word_of(39)) begin
      bad++;
      $display("FAIL R8: data_out=%h expected %h", data_out, word_of(39));
    end

    // R9 resume with latch-enable low
    cur_req = "R9";
    cs_n = 1'b0;
    @(negedge clk); check_oe("R2", 1'b1);
    do_beat();   check_word("R9", 40);
    do_beat();   check_word("R9", 41);

    // R7 wrap from odd and even starts
    cur_req = "R7";
    do_nla(NWORD - 1); check_word("R7", NWORD - 1);
    do_beat();         check_word("R7", 0);
    do_beat();         check_word("R7", 1);
    do_nla(NWORD - 2); check_word("R7", NWORD - 2);
    do_beat();         check_word("R7", NWORD - 1);
    do_beat();         check_word("R7", 0);

    // R10 reselect with latch-enable high
    cur_req = "R10";
    cs_n = 1'b1; repeat (3) @(negedge clk);
    do_nla(66);  check_word("R10", 66);
    do_beat();   check_word("R10", 67);

    // R11 level-held strobe and strobe during latch-enable
    cur_req = "R11";
    rd = 1'b1; repeat (6) @(negedge clk);
    check_word("R11", 68);
    rd = 1'b0; @(negedge clk);
    ale = 1'b1; addr = 9'd100;
    for (int k = 0; k < 3; k++) begin
      rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    end
    ale = 1'b0; @(negedge clk); @(negedge clk);
    check_word("R11", 100);
    do_beat();   check_word("R11", 101);

    // mixed stimulus against the model
    cur_req = "R3";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom % 64);
      ale  = (r % 13 == 0);
      cs_n = (r % 11 == 0);
      rd   = r[0];
      addr = (BANK_AW + 1)'($urandom);
      @(negedge clk);
    end
    ale = 1'b0; rd = 1'b0; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule